// File: doc/BRIEF.md
# Memory Traffic Generator and Checker

This block is a built-in self-test engine for a memory subsystem. It acts as a burst-capable Avalon-MM master. When started, it writes a sequence of bursts whose data comes from a linear feedback shift register (LFSR). After each write burst it issues one read burst to the same addresses. It then compares every returned word with the pattern that was written. The LFSR is re-seeded from each burst's start address, so the expected data is regenerated rather than stored.

The engine reports done, pass and fail, and a timeout flag. A watchdog counter watches the memory side. If the slave holds waitrequest for too long, or never returns read data that is owed, the engine abandons the test, flags a timeout and failure, and finishes. Done is raised only in a state where no burst command is outstanding. This makes it safe to reset or restart the engine when done is high.

Top module: `mtg_engine`

## Requirements
- R1: While reset is held and after its release, `avm_write`, `avm_read`, `done`, `pass`, `fail` and `timeout` are all low until a test is started.
- R2: A start runs `NUM_BURSTS` write bursts of `BURST_LEN` beats each. Burst b uses word address b*`BURST_LEN`. Every command presents `avm_burstcount` = `BURST_LEN` and byte enables all ones. `avm_beginbursttransfer` is high for exactly the first cycle of each write command and each read command, which gives 2*`NUM_BURSTS` pulses per test.
- R3: Each burst's data starts at the seed 32'h1D0F0000 XOR (burst start address, zero-extended). Each following beat is x<<1, XORed with 32'h04C11DB7 when bit 31 of x was set.
- R4: Each write burst completes all its beats before one read command with the same address and burstcount is issued. The engine never asserts write and read together.
- R5: Each word returned with `avm_readdatavalid` is compared with the regenerated pattern. Any mismatch sets `fail`, which stays set until the next start. `pass` is high only when `done` is high and `fail` is low.
- R6: While `avm_waitrequest` holds a pending command, address, write, read, burstcount and write data stay unchanged in the next cycle, unless a timeout ends the test.
- R7: The watchdog clears on every accepted command and every `avm_readdatavalid`, and counts every other cycle in which a transfer is outstanding. When it reaches `TIMEOUT_MAX`, the test ends with `timeout` and `fail` set, and `done` follows two cycles later.
- R8: A stall shorter than `TIMEOUT_MAX` cycles does not cause a timeout, and the test still passes.
- R9: `done` is high only while no read or write command is presented.
- R10: A start seen while a test is running has no effect. A start seen while done is high begins a new test and clears fail and timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Starts a test when idle or done |
| avm_address | output | ADDR_W | Word address of the burst |
| avm_write | output | 1 | Write request |
| avm_read | output | 1 | Read request |
| avm_writedata | output | 32 | Write data beat |
| avm_byteenable | output | 4 | Byte enables, all ones |
| avm_burstcount | output | BC_W | Burst length in beats |
| avm_beginbursttransfer | output | 1 | First-cycle marker of each burst command |
| avm_waitrequest | input | 1 | Slave stall |
| avm_readdata | input | 32 | Read data |
| avm_readdatavalid | input | 1 | Read data valid |
| done | output | 1 | Test finished, nothing outstanding |
| pass | output | 1 | Finished without mismatch or timeout |
| fail | output | 1 | Sticky mismatch or timeout indication |
| timeout | output | 1 | Watchdog expired during this test |

## Verification
The engine runs against a behavioural memory in several patterns, and each pattern separates a different class of fault. A clean memory with no stalls shows the basic pattern and burst ordering. Random waitrequest and random gaps in read data show whether commands are held and beats are counted correctly under backpressure. One corrupted read word shows whether the comparison is actually made. A permanently stalled waitrequest and a read that never returns separate the two paths into a timeout. A single stall just below the limit shows that the watchdog does not fire early. A start issued during a run, and a restart after a failed run, show that start is ignored while busy and that the flags are cleared on a new test.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
  localparam int PAT_W = 32;
  localparam logic [PAT_W-1:0] PAT_SEED_BASE = 32'h1D0F_0000;
  localparam logic [PAT_W-1:0] PAT_POLY      = 32'h04C1_1DB7;

  typedef enum logic [2:0] {
    S_IDLE, S_WRITE, S_RDREQ, S_RDWAIT, S_NEXT, S_TIMEOUT, S_DONE
  } mtg_state_e;

  function automatic logic [PAT_W-1:0] pat_step(input logic [PAT_W-1:0] x);
    return {x[PAT_W-2:0], 1'b0} ^ (x[PAT_W-1] ? PAT_POLY : '0);
  endfunction
endpackage

// File: rtl/mtg_watchdog.sv
module mtg_watchdog #(
  parameter int          CNT_W   = 32,
  parameter logic [31:0] CNT_MAX = 32'hFFFF_FFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic kick,
  output logic expired
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = !active || kick || (cnt_q != LIMIT);

  always_comb begin
    if (!active || kick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = active && (cnt_q == LIMIT);
endmodule

// File: rtl/mtg_pattern.sv
module mtg_pattern #(
  parameter int ADDR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         seed_addr,
  input  logic                      step,
  output logic [mtg_pkg::PAT_W-1:0] word
);
  import mtg_pkg::*;
  logic [PAT_W-1:0] lfsr_q, lfsr_d;
  logic             lfsr_en;

  assign lfsr_en = load || step;

  always_comb begin
    if (load) lfsr_d = PAT_SEED_BASE ^ PAT_W'(seed_addr);
    else      lfsr_d = pat_step(lfsr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr_q <= '0;
    else if (lfsr_en) lfsr_q <= lfsr_d;
  end

  assign word = lfsr_q;
endmodule

// File: rtl/mtg_engine.sv
module mtg_engine #(
  parameter int          ADDR_W      = 16,
  parameter int          BURST_LEN   = 4,
  parameter int          NUM_BURSTS  = 8,
  parameter logic [31:0] TIMEOUT_MAX = 32'hFFFF_FFFF,
  localparam int         BC_W        = $clog2(BURST_LEN + 1),
  localparam int         DW          = mtg_pkg::PAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_write,
  output logic              avm_read,
  output logic [DW-1:0]     avm_writedata,
  output logic [DW/8-1:0]   avm_byteenable,
  output logic [BC_W-1:0]   avm_burstcount,
  output logic              avm_beginbursttransfer,
  input  logic              avm_waitrequest,
  input  logic [DW-1:0]     avm_readdata,
  input  logic              avm_readdatavalid,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              timeout
);
  import mtg_pkg::*;
  localparam int BEAT_W  = (BURST_LEN  > 1) ? $clog2(BURST_LEN)  : 1;
  localparam int BURST_W = (NUM_BURSTS > 1) ? $clog2(NUM_BURSTS) : 1;
  localparam logic [BEAT_W-1:0]  LAST_BEAT  = BEAT_W'(BURST_LEN - 1);
  localparam logic [BURST_W-1:0] LAST_BURST = BURST_W'(NUM_BURSTS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mtg_state_e         state_q, state_d;
  logic [BURST_W-1:0] burst_q, burst_d;
  logic [BEAT_W-1:0]  beat_q, beat_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic               fail_q, fail_d, to_q, to_d, first_q, first_d;
  logic               pat_load, pat_step_en, wd_expired, wd_active, wd_kick;
  logic [ADDR_W-1:0]  pat_addr;
  logic [DW-1:0]      pat_word;

  mtg_pattern #(.ADDR_W(ADDR_W)) pat_i (
    .clk(clk), .rst_n(rst_int_n), .load(pat_load), .seed_addr(pat_addr),
    .step(pat_step_en), .word(pat_word));

  assign wd_active = (state_q == S_WRITE) || (state_q == S_RDREQ) || (state_q == S_RDWAIT);
  assign wd_kick   = ((avm_write || avm_read) && !avm_waitrequest) || avm_readdatavalid;

  mtg_watchdog #(.CNT_W(32), .CNT_MAX(TIMEOUT_MAX)) wd_i (
    .clk(clk), .rst_n(rst_int_n), .active(wd_active), .kick(wd_kick),
    .expired(wd_expired));

  always_comb begin
    state_d = state_q;  burst_d = burst_q;  beat_d = beat_q;  base_d = base_q;
    fail_d = fail_q;    to_d = to_q;        first_d = 1'b0;
    pat_load = 1'b0;    pat_step_en = 1'b0; pat_addr = base_q;
    unique case (state_q)
      S_IDLE, S_DONE: if (start) begin
        state_d = S_WRITE; burst_d = '0; beat_d = '0; base_d = '0;
        fail_d = 1'b0; to_d = 1'b0; first_d = 1'b1;
        pat_load = 1'b1; pat_addr = '0;
      end
      S_WRITE: begin
        if (wd_expired) begin
          state_d = S_TIMEOUT; fail_d = 1'b1; to_d = 1'b1;
        end else if (!avm_waitrequest) begin
          if (beat_q == LAST_BEAT) begin
            state_d = S_RDREQ; beat_d = '0; first_d = 1'b1; pat_load = 1'b1;
          end else begin
            beat_d = beat_q + 1'b1; pat_step_en = 1'b1;
          end
        end
      end
      S_RDREQ: begin
        if (wd_expired) begin
          state_d = S_TIMEOUT; fail_d = 1'b1; to_d = 1'b1;
        end else if (!avm_waitrequest) state_d = S_RDWAIT;
      end
      S_RDWAIT: begin
        if (wd_expired) begin
          state_d = S_TIMEOUT; fail_d = 1'b1; to_d = 1'b1;
        end else if (avm_readdatavalid) begin
          if (avm_readdata != pat_word) fail_d = 1'b1;
          pat_step_en = 1'b1;
          if (beat_q == LAST_BEAT) begin
            state_d = S_NEXT; beat_d = '0;
          end else beat_d = beat_q + 1'b1;
        end
      end
      S_NEXT: begin
        if (burst_q == LAST_BURST) state_d = S_DONE;
        else begin
          state_d = S_WRITE; burst_d = burst_q + 1'b1; first_d = 1'b1;
          base_d = base_q + ADDR_W'(BURST_LEN);
          pat_load = 1'b1; pat_addr = base_d;
        end
      end
      S_TIMEOUT: state_d = S_DONE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE; burst_q <= '0; beat_q <= '0; base_q <= '0;
      fail_q <= 1'b0; to_q <= 1'b0; first_q <= 1'b0;
    end else begin
      state_q <= state_d; burst_q <= burst_d; beat_q <= beat_d; base_q <= base_d;
      fail_q <= fail_d; to_q <= to_d; first_q <= first_d;
    end
  end

  assign avm_write              = (state_q == S_WRITE);
  assign avm_read               = (state_q == S_RDREQ);
  assign avm_address            = base_q;
  assign avm_writedata          = pat_word;
  assign avm_byteenable         = '1;
  assign avm_burstcount         = BC_W'(BURST_LEN);
  assign avm_beginbursttransfer = first_q && (avm_write || avm_read);
  assign done                   = (state_q == S_DONE);
  assign pass                   = done && !fail_q;
  assign fail                   = fail_q;
  assign timeout                = to_q;
endmodule

// File: rtl/mtg_engine_chk.sv
module mtg_engine_chk #(
  parameter int ADDR_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int BC_W      = 3,
  parameter int DW        = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] avm_address,
  input logic              avm_write,
  input logic              avm_read,
  input logic [DW-1:0]     avm_writedata,
  input logic [BC_W-1:0]   avm_burstcount,
  input logic              avm_beginbursttransfer,
  input logic              avm_waitrequest,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic              timeout
);
  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (avm_write || avm_read) && avm_waitrequest |=> timeout ||
      ($stable(avm_address) && $stable(avm_write) && $stable(avm_read) &&
       $stable(avm_burstcount) && $stable(avm_writedata)));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !avm_write && !avm_read);

  p_pass_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  p_timeout_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fail);

  p_one_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({avm_write, avm_read}) <= 1);

  p_burst_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (avm_write || avm_read) |-> (avm_burstcount == BC_W'(BURST_LEN)));

  p_begin_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    avm_beginbursttransfer |-> (avm_write || avm_read));
endmodule

bind mtg_engine mtg_engine_chk #(
  .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .BC_W(BC_W), .DW(DW)
) chk_i (.*);

// File: tb/mtg_engine_tb.sv
module mtg_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16, LEN = 4, NB = 6, LIM = 200, BCW = $clog2(LEN + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [ADDR_W-1:0] avm_address;
  logic avm_write, avm_read, avm_beginbursttransfer, done, pass, fail, timeout;
  logic [31:0] avm_writedata, avm_readdata;
  logic [3:0] avm_byteenable;
  logic [BCW-1:0] avm_burstcount;
  logic wr_q = 1'b0, rdv_q = 1'b0;

  int checks = 0, fails = 0;
  int stall_pct = 0, gap_pct = 0, corrupt_idx = -1, fixed_left = 0;
  bit hang_wait = 0, hang_read = 0;
  int begin_cnt = 0, wacc_cnt = 0, rd_left = 0, rd_seen = 0, wbeat = 0;
  logic [7:0] rd_ptr = '0;
  logic [31:0] mem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  mtg_engine #(.ADDR_W(ADDR_W), .BURST_LEN(LEN), .NUM_BURSTS(NB),
               .TIMEOUT_MAX(32'(LIM))) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .avm_address(avm_address),
    .avm_write(avm_write), .avm_read(avm_read), .avm_writedata(avm_writedata),
    .avm_byteenable(avm_byteenable), .avm_burstcount(avm_burstcount),
    .avm_beginbursttransfer(avm_beginbursttransfer), .avm_waitrequest(wr_q),
    .avm_readdata(avm_readdata), .avm_readdatavalid(rdv_q), .done(done),
    .pass(pass), .fail(fail), .timeout(timeout));

  // behavioural memory responder
  always @(posedge clk) begin
    if (avm_beginbursttransfer) begin_cnt <= begin_cnt + 1;
    if (avm_write && !wr_q) begin
      mem[8'(avm_address) + 8'(wbeat)] <= avm_writedata;
      wbeat <= (wbeat == LEN - 1) ? 0 : wbeat + 1;
      wacc_cnt <= wacc_cnt + 1;
    end
    if (avm_read && !wr_q) begin
      rd_left <= LEN; rd_ptr <= 8'(avm_address);
    end
    rdv_q <= 1'b0;
    if (rd_left > 0 && !hang_read && $urandom_range(99) >= gap_pct) begin
      rdv_q <= 1'b1;
      avm_readdata <= mem[rd_ptr] ^ ((rd_seen == corrupt_idx) ? 32'h1 : 32'h0);
      rd_ptr <= rd_ptr + 8'd1; rd_left <= rd_left - 1; rd_seen <= rd_seen + 1;
    end
    if (fixed_left > 0) fixed_left <= fixed_left - 1;
    wr_q <= hang_wait || (fixed_left > 0) || ($urandom_range(99) < stall_pct);
  end

  function automatic logic [31:0] exp_word(int burst, int beat);
    logic [31:0] x = 32'h1D0F_0000 ^ 32'(burst * LEN);
    for (int i = 0; i < beat; i++) x = {x[30:0], 1'b0} ^ (x[31] ? 32'h04C1_1DB7 : 32'h0);
    return x;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic prep(int sp, int gp, int ci, bit hw, bit hr, int fx);
    @(negedge clk);
    stall_pct = sp; gap_pct = gp; corrupt_idx = ci; hang_wait = hw; hang_read = hr;
    fixed_left = fx; begin_cnt = 0; wacc_cnt = 0; rd_left = 0; rd_seen = 0; wbeat = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done, req, "done reached", 32'(done), 32'h1);
  endtask

  task automatic check_mem(string req);
    for (int b = 0; b < NB; b++) begin
      bit ok = 1'b1;
      for (int k = 0; k < LEN; k++) if (mem[b*LEN + k] != exp_word(b, k)) ok = 1'b0;
      check(ok, req, "written pattern", mem[b*LEN], exp_word(b, 0));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    prep(0, 0, -1, 0, 0, 0);
    repeat (3) @(negedge clk);
    check({avm_write, avm_read, done, pass, fail, timeout} == 6'b0, "R1", "in reset",
          32'({avm_write, avm_read, done, pass, fail, timeout}), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({avm_write, avm_read, done, pass, fail, timeout} == 6'b0, "R1", "after reset",
          32'({avm_write, avm_read, done, pass, fail, timeout}), 32'h0);

    // clean memory, no stalls
    pulse_start(); wait_done("R2");
    check(pass && !fail && !timeout, "R5", "clean pass", 32'({pass, fail, timeout}), 32'b100);
    check(begin_cnt == 2*NB, "R2", "begin pulses", 32'(begin_cnt), 32'(2*NB));
    check(wacc_cnt == NB*LEN, "R4", "write beats", 32'(wacc_cnt), 32'(NB*LEN));
    check(rd_seen == NB*LEN, "R4", "read beats", 32'(rd_seen), 32'(NB*LEN));
    check(avm_byteenable == 4'hF, "R2", "byte enables", 32'(avm_byteenable), 32'hF);
    check_mem("R3");
    repeat (5) @(negedge clk);
    check(done && !avm_write && !avm_read, "R9", "quiet when done",
          32'({done, avm_write, avm_read}), 32'b100);

    // random backpressure and read gaps, plus a start while running
    prep(45, 40, -1, 0, 0, 0);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_done("R6");
    check(pass && !timeout, "R6", "pass under stalls", 32'({pass, timeout}), 32'b10);
    check(begin_cnt == 2*NB, "R10", "start ignored while busy", 32'(begin_cnt), 32'(2*NB));
    check_mem("R6");

    // one corrupted read word
    prep(20, 20, 9, 0, 0, 0);
    pulse_start(); wait_done("R5");
    check(fail && !pass && !timeout, "R5", "mismatch fails", 32'({pass, fail, timeout}), 32'b010);
    repeat (3) @(negedge clk);
    check(fail, "R5", "fail sticky", 32'(fail), 32'h1);

    // restart after failure clears flags
    prep(0, 0, -1, 0, 0, 0);
    pulse_start();
    check(!fail && !done, "R10", "flags cleared on restart", 32'({fail, done}), 32'b00);
    wait_done("R10");
    check(pass, "R10", "restart passes", 32'(pass), 32'h1);

    // waitrequest stuck high: timeout at limit
    prep(0, 0, -1, 1, 0, 0);
    pulse_start();
    repeat (LIM - 1) @(negedge clk);
    check(!done && !timeout, "R7", "no early timeout", 32'({done, timeout}), 32'b00);
    repeat (5) @(negedge clk);
    check(done && timeout && fail && !pass, "R7", "stuck wait timeout",
          32'({done, timeout, fail, pass}), 32'b1110);
    check(!avm_write && !avm_read, "R9", "no command after abort",
          32'({avm_write, avm_read}), 32'b00);

    // read data never returned
    prep(0, 0, -1, 0, 1, 0);
    pulse_start(); wait_done("R7");
    check(timeout && fail && !pass, "R7", "missing read data timeout",
          32'({timeout, fail, pass}), 32'b110);
    check(begin_cnt == 2, "R7", "aborted in first read", 32'(begin_cnt), 32'h2);

    // stall just below the limit
    prep(0, 0, -1, 0, 0, LIM - 20);
    pulse_start(); wait_done("R8");
    check(pass && !timeout, "R8", "long stall survives", 32'({pass, timeout}), 32'b10);
    check_mem("R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule